// File: doc/BRIEF.md
# Word Programming Sequencer for a UV-Erasable Memory

This block writes a run of 16-bit words into a UV-erasable memory that can only clear bits. After a start request it latches a base address and the index of the last word. For each index it fetches the intended word from a word source and reads the memory location back. It then applies fixed-width, active-low program pulses, with a read-back after each pulse, until the read matches. Once a word matches, the block moves straight to the next address and applies no extra pulse.

An erased cell reads as 1, and a pulse can only pull bits to 0. A word that needs a 0 turned back into a 1 therefore cannot be written. The block flags such a word as a conflict and stops. It also stops when a word still mismatches after the maximum number of pulses. In both cases it latches the failing address. The high-voltage-enable output is the only hook to the external programming supply. It is high while a sequence runs and falls in the cycle that `done` pulses.

Top module: `wordprog_seq`

## Requirements
- R1: In reset and after it, the block is idle. `busy`, `done`, `hv_en` and `mem_dq_oe` are low. `mem_ce_n`, `mem_oe_n` and `mem_pgm_n` are high.
- R2: Each word is read back before any pulse is applied. A location that already holds the intended word receives zero program pulses.
- R3: Each program pulse holds `mem_pgm_n` low for exactly `(CLK_HZ/1e6)*PULSE_US` cycles. During a pulse `mem_ce_n` is low, `hv_en` is high and `mem_dq_oe` is high.
- R4: Before `mem_pgm_n` falls, address and data have been driven and stable for at least `SETUP_CYC` cycles. They stay driven for at least `HOLD_CYC` cycles after it rises.
- R5: `mem_oe_n` is low only while `mem_dq_oe` is low. At least one cycle with both high and off separates the bus being driven from `mem_oe_n` being low, in either direction.
- R6: A word receives pulses until the read-back equals it. The count of pulses equals the number of pulses the location needs, and no pulse follows a matching read.
- R7: A read-back that holds 0 where the intended word holds 1 sets `err_conflict`. It also loads the address into `err_addr` and ends the sequence with no pulse applied to that word.
- R8: A word that still mismatches after `MAX_PULSES` pulses sets `err_limit`. It also loads its address into `err_addr` and ends the sequence.
- R9: After the word at index `last_idx` matches, `done` is high for exactly one cycle with `hv_en` low, and `busy` falls after it. `done` does not pulse when a sequence ends with an error.
- R10: `hv_en` stays high in every busy cycle except the `done` cycle.
- R11: Word i is taken from `src_word` while `src_idx` equals i and is written to `base_addr + i`. Indices run in ascending order from 0 to `last_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a sequence when idle |
| base_addr | input | ADDR_W | Memory address of index 0, latched at start |
| last_idx | input | IDX_W | Index of the final word, latched at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| src_idx | output | IDX_W | Index of the word requested from the source |
| src_word | input | 16 | Intended word for `src_idx` |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| hv_en | output | 1 | Request for the programming supply |
| err_conflict | output | 1 | Sticky: a 0 would need to become 1 |
| err_limit | output | 1 | Sticky: pulse limit exhausted |
| err_addr | output | ADDR_W | Address of the failing word |

## Verification
The bench sets `CLK_HZ` to 1 MHz, so a pulse is 100 cycles and each run of several words finishes in a few thousand cycles. `MAX_PULSES` is cut to 4, so a location needing five pulses reaches the limit path, and one needing exactly four tests the boundary where the last permitted pulse succeeds. Short setup, hold and access counts of 2, 3 and 3 keep the bus turnaround checks dense. An 8-word window with a base address that is a multiple of 8 lets a bench memory model count pulses per location.

// File: rtl/wordprog_pkg.sv
package wordprog_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_READ,
        S_CHECK,
        S_SETUP,
        S_STROBE,
        S_HOLD,
        S_TURN,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic match;
        logic conflict;
    } verdict_t;

    function automatic int unsigned cycles_for_us(int unsigned hz, int unsigned us);
        return (hz / 1_000_000) * us;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Cells can only be cleared; a wanted 1 over a read 0 is unreachable.
    function automatic verdict_t judge(word_t want, word_t seen);
        verdict_t v;
        v.match    = (want == seen);
        v.conflict = |(want & ~seen);
        return v;
    endfunction

endpackage

// File: rtl/wordprog_timer.sv
module wordprog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/wordprog_cmp.sv
module wordprog_cmp
    import wordprog_pkg::*;
(
    input  word_t    want,
    input  word_t    seen,
    output verdict_t verdict
);
    always_comb verdict = judge(want, seen);
endmodule

// File: rtl/wordprog_seq.sv
module wordprog_seq
    import wordprog_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned PULSE_US   = 100,
    parameter int unsigned SETUP_CYC  = 4,
    parameter int unsigned HOLD_CYC   = 4,
    parameter int unsigned ACCESS_CYC = 8,
    parameter int unsigned MAX_PULSES = 25,
    parameter int          ADDR_W     = 16,
    parameter int          IDX_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  src_idx,
    input  logic [WORD_W-1:0] src_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [WORD_W-1:0] mem_dq_i,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_pgm_n,
    output logic              hv_en,
    output logic              err_conflict,
    output logic              err_limit,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int unsigned PULSE_CYC = cycles_for_us(CLK_HZ, PULSE_US);
    localparam int unsigned TMR_MAX   = max3(PULSE_CYC, max3(SETUP_CYC, HOLD_CYC, ACCESS_CYC), 1);
    localparam int          TMR_W     = $clog2(TMR_MAX + 1);
    localparam int          PC_W      = $clog2(MAX_PULSES + 1);

    seq_state_t        st, st_n;
    logic [IDX_W-1:0]  idx, last_q;
    logic [ADDR_W-1:0] base_q;
    word_t             want_q, seen_q;
    logic [PC_W-1:0]   npulse;
    logic              tload, tzero;
    logic [TMR_W-1:0]  tval;
    verdict_t          vd;
    logic              at_last, at_limit;

    wordprog_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tval),
        .zero     (tzero)
    );

    wordprog_cmp u_cmp (
        .want    (want_q),
        .seen    (seen_q),
        .verdict (vd)
    );

    assign at_last  = (idx == last_q);
    assign at_limit = (npulse == PC_W'(MAX_PULSES));

    // Next state and phase timer reload
    always_comb begin
        st_n  = st;
        tload = 1'b0;
        tval  = '0;
        unique case (st)
            S_IDLE:  if (start) st_n = S_LOAD;
            S_LOAD: begin
                st_n  = S_READ;
                tload = 1'b1;
                tval  = TMR_W'(ACCESS_CYC - 1);
            end
            S_READ:  if (tzero) st_n = S_CHECK;
            S_CHECK: begin
                if (vd.match)
                    st_n = at_last ? S_DONE : S_LOAD;
                else if (vd.conflict || at_limit)
                    st_n = S_IDLE;
                else begin
                    st_n  = S_SETUP;
                    tload = 1'b1;
                    tval  = TMR_W'(SETUP_CYC - 1);
                end
            end
            S_SETUP: if (tzero) begin
                st_n  = S_STROBE;
                tload = 1'b1;
                tval  = TMR_W'(PULSE_CYC - 1);
            end
            S_STROBE: if (tzero) begin
                st_n  = S_HOLD;
                tload = 1'b1;
                tval  = TMR_W'(HOLD_CYC - 1);
            end
            S_HOLD:  if (tzero) st_n = S_TURN;
            S_TURN: begin
                st_n  = S_READ;
                tload = 1'b1;
                tval  = TMR_W'(ACCESS_CYC - 1);
            end
            S_DONE:  st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            idx          <= '0;
            last_q       <= '0;
            base_q       <= '0;
            want_q       <= '0;
            seen_q       <= '0;
            npulse       <= '0;
            err_conflict <= 1'b0;
            err_limit    <= 1'b0;
            err_addr     <= '0;
        end else begin
            st <= st_n;
            unique case (st)
                S_IDLE: if (start) begin
                    base_q       <= base_addr;
                    last_q       <= last_idx;
                    idx          <= '0;
                    err_conflict <= 1'b0;
                    err_limit    <= 1'b0;
                end
                S_LOAD: begin
                    want_q <= src_word;
                    npulse <= '0;
                end
                S_READ: if (tzero) seen_q <= mem_dq_i;
                S_CHECK: begin
                    if (vd.match) begin
                        if (!at_last) idx <= idx + 1'b1;
                    end else if (vd.conflict) begin
                        err_conflict <= 1'b1;
                        err_addr     <= mem_addr;
                    end else if (at_limit) begin
                        err_limit <= 1'b1;
                        err_addr  <= mem_addr;
                    end
                end
                S_SETUP: if (tzero) npulse <= npulse + 1'b1;
                default: ;
            endcase
        end
    end

    // Pin levels follow the phase
    always_comb begin
        busy      = (st != S_IDLE);
        done      = (st == S_DONE);
        hv_en     = (st != S_IDLE) && (st != S_DONE);
        mem_ce_n  = !hv_en;
        mem_oe_n  = (st != S_READ);
        mem_pgm_n = (st != S_STROBE);
        mem_dq_oe = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
        mem_dq_o  = want_q;
        mem_addr  = base_q + ADDR_W'(idx);
        src_idx   = idx;
    end

endmodule

// File: rtl/wordprog_chk.sv
module wordprog_chk #(
    parameter int unsigned PULSE_CYC = 100,
    parameter int unsigned SETUP_CYC = 4,
    parameter int unsigned HOLD_CYC  = 4,
    parameter int          ADDR_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_dq_o,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_pgm_n,
    input logic              hv_en,
    input logic              err_conflict,
    input logic              err_limit
);
    logic [31:0]       low_cnt, stab_cnt, high_cnt;
    logic [ADDR_W-1:0] addr_prev;
    logic [15:0]       dq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            stab_cnt  <= '0;
            high_cnt  <= '0;
            addr_prev <= '0;
            dq_prev   <= '0;
        end else begin
            low_cnt   <= mem_pgm_n ? '0 : low_cnt + 1;
            high_cnt  <= !mem_pgm_n ? '0 : ((high_cnt == 32'hFFFF_FFFF) ? high_cnt : high_cnt + 1);
            stab_cnt  <= (mem_dq_oe && mem_addr == addr_prev && mem_dq_o == dq_prev) ? stab_cnt + 1 : '0;
            addr_prev <= mem_addr;
            dq_prev   <= mem_dq_o;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (mem_pgm_n && mem_oe_n && mem_ce_n && !hv_en && !mem_dq_oe && !busy && !done));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_pgm_n) |-> (low_cnt == PULSE_CYC));

    a_r3_pulse_context: assert property (@(posedge clk) disable iff (rst)
        !mem_pgm_n |-> (!mem_ce_n && hv_en && mem_dq_oe));

    a_r4_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_pgm_n) |-> (stab_cnt >= SETUP_CYC));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_oe) |-> (high_cnt >= HOLD_CYC));

    a_r4_stable_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (!mem_pgm_n && !$fell(mem_pgm_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    a_r5_gap_before_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    a_r5_gap_before_read: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r9_done_hv_off: assert property (@(posedge clk) disable iff (rst)
        done |-> !hv_en);

    a_r7_conflict_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(err_conflict) |-> (!busy && !done));

    a_r8_limit_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(err_limit) |-> (!busy && !done));

endmodule

bind wordprog_seq wordprog_chk #(
    .PULSE_CYC (PULSE_CYC),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .mem_addr     (mem_addr),
    .mem_dq_o     (mem_dq_o),
    .mem_dq_oe    (mem_dq_oe),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .mem_pgm_n    (mem_pgm_n),
    .hv_en        (hv_en),
    .err_conflict (err_conflict),
    .err_limit    (err_limit)
);

// File: tb/test_wordprog_seq.sv
module test_wordprog_seq;
    localparam int unsigned CLK_HZ    = 1_000_000;
    localparam int unsigned PULSE_US  = 100;
    localparam int unsigned PULSE_CYC = 100;
    localparam int unsigned SETUP     = 2;
    localparam int unsigned HOLD      = 3;
    localparam int unsigned ACCESS    = 3;
    localparam int unsigned MAXP      = 4;
    localparam int          ADDR_W    = 16;
    localparam int          IDX_W     = 8;
    localparam int          NW        = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [IDX_W-1:0]  last_idx = '0;
    logic              busy, done;
    logic [IDX_W-1:0]  src_idx;
    logic [15:0]       src_word;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_dq_o, mem_dq_i;
    logic              mem_dq_oe, mem_ce_n, mem_oe_n, mem_pgm_n, hv_en;
    logic              err_conflict, err_limit;
    logic [ADDR_W-1:0] err_addr;

    always #4 clk = ~clk;

    wordprog_seq #(
        .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
        .ACCESS_CYC(ACCESS), .MAX_PULSES(MAXP), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) i_wordprog_seq (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .last_idx(last_idx),
        .busy(busy), .done(done), .src_idx(src_idx), .src_word(src_word),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n), .hv_en(hv_en),
        .err_conflict(err_conflict), .err_limit(err_limit), .err_addr(err_addr)
    );

    // Memory model: a location clears bits once it has seen need[] pulses
    logic [15:0] init_mem [NW];
    logic [15:0] tgt      [NW];
    int          need     [NW];
    logic [15:0] mem      [NW];
    int          pc       [NW];
    logic        clr_req = 1'b0;
    logic        pgm_prev = 1'b1;
    int          low_cnt = 0, stab = 0;
    logic [15:0] dq_prev = '0;
    logic [ADDR_W-1:0] addr_prev = '0;
    int          wbad = 0, sbad = 0, pbad = 0, oob = 0, hvbad = 0, cbad = 0, done_cnt = 0;

    assign src_word = tgt[src_idx[2:0]];
    assign mem_dq_i = (!mem_oe_n && !mem_ce_n) ? mem[mem_addr[2:0]] : 16'hDEAD;

    always @(posedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < NW; i++) begin
                mem[i] <= init_mem[i];
                pc[i]  <= 0;
            end
        end else if (pgm_prev && !mem_pgm_n) begin
            pc[mem_addr[2:0]] <= pc[mem_addr[2:0]] + 1;
            if (pc[mem_addr[2:0]] + 1 >= need[mem_addr[2:0]])
                mem[mem_addr[2:0]] <= mem[mem_addr[2:0]] & mem_dq_o;
            if (mem_addr[ADDR_W-1:3] != base_addr[ADDR_W-1:3]) oob <= oob + 1;
            if (stab < int'(SETUP)) sbad <= sbad + 1;
        end
        if (!mem_pgm_n && (mem_ce_n || !mem_dq_oe || !hv_en)) pbad <= pbad + 1;
        if (!pgm_prev && mem_pgm_n && low_cnt != int'(PULSE_CYC)) wbad <= wbad + 1;
        if (!mem_oe_n && mem_dq_oe) cbad <= cbad + 1;
        if (busy && !done && !hv_en) hvbad <= hvbad + 1;
        if (done) done_cnt <= done_cnt + 1;
        low_cnt   <= mem_pgm_n ? 0 : low_cnt + 1;
        stab      <= (mem_dq_oe && mem_dq_o == dq_prev && mem_addr == addr_prev) ? stab + 1 : 0;
        pgm_prev  <= mem_pgm_n;
        dq_prev   <= mem_dq_o;
        addr_prev <= mem_addr;
    end

    int checks = 0, fails = 0;

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One sequence over words 0..last at base; expectations from the rules
    task automatic run(input logic [ADDR_W-1:0] base, input int last);
        int          exp_pc [NW];
        logic [15:0] exp_mem[NW];
        logic        e_conf, e_lim, stopped;
        logic [ADDR_W-1:0] e_addr;
        int d0, w0, s0, p0, o0, h0, c0;
        e_conf = 0; e_lim = 0; stopped = 0; e_addr = '0;
        for (int i = 0; i < NW; i++) begin
            exp_pc[i]  = 0;
            exp_mem[i] = init_mem[i];
        end
        for (int i = 0; i <= last; i++) begin
            if (!stopped) begin
                if (init_mem[i] == tgt[i]) exp_pc[i] = 0;
                else if ((tgt[i] & ~init_mem[i]) != 0) begin
                    e_conf = 1; e_addr = base + ADDR_W'(i); stopped = 1;
                end else if (need[i] > int'(MAXP)) begin
                    exp_pc[i] = MAXP; e_lim = 1; e_addr = base + ADDR_W'(i); stopped = 1;
                end else begin
                    exp_pc[i] = need[i]; exp_mem[i] = tgt[i];
                end
            end
        end
        @(negedge clk) clr_req = 1;
        @(negedge clk) clr_req = 0;
        d0 = done_cnt; w0 = wbad; s0 = sbad; p0 = pbad; o0 = oob; h0 = hvbad; c0 = cbad;
        base_addr = base; last_idx = IDX_W'(last); start = 1;
        @(negedge clk) start = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(done_cnt - d0 == (stopped ? 0 : 1), "R9 done pulses", done_cnt - d0, stopped ? 0 : 1);
        chk(err_conflict == e_conf, "R7 err_conflict", err_conflict, e_conf);
        chk(err_limit == e_lim, "R8 err_limit", err_limit, e_lim);
        if (stopped) chk(err_addr == e_addr, "R7/R8 err_addr", err_addr, e_addr);
        for (int i = 0; i < NW; i++) begin
            if (exp_pc[i] == 0) chk(pc[i] == 0, "R2 no pulse on matching/untouched word", pc[i], 0);
            else chk(pc[i] == exp_pc[i], "R6 pulse count", pc[i], exp_pc[i]);
            chk(mem[i] == exp_mem[i], "R11 final word", mem[i], exp_mem[i]);
        end
        chk(wbad == w0, "R3 pulse width", wbad - w0, 0);
        chk(pbad == p0, "R3 pulse context", pbad - p0, 0);
        chk(sbad == s0, "R4 setup before strobe", sbad - s0, 0);
        chk(cbad == c0, "R5 bus contention", cbad - c0, 0);
        chk(hvbad == h0, "R10 hv_en during busy", hvbad - h0, 0);
        chk(oob == o0, "R11 address window", oob - o0, 0);
        chk(!busy && !hv_en, "R9 idle after end", {busy, hv_en}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired actual=busy expected=idle");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) begin
            init_mem[i] = 16'hFFFF; tgt[i] = 16'hFFFF; need[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !hv_en && !mem_dq_oe, "R1 idle outputs low", {busy, done, hv_en, mem_dq_oe}, 0);
        chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1 strobes high", {mem_ce_n, mem_oe_n, mem_pgm_n}, 7);

        // R2: erased and wanted all ones, no pulses at all
        run(16'h0100, NW - 1);

        // R6 boundary: single word needing exactly MAXP pulses succeeds
        init_mem[0] = 16'hFFFF; tgt[0] = 16'h1234; need[0] = MAXP;
        run(16'h0208, 0);

        // R7: conflict at index 3
        for (int i = 0; i < NW; i++) begin
            init_mem[i] = 16'hFFFF; tgt[i] = 16'hA5A5 ^ 16'(i); need[i] = 2;
        end
        init_mem[3] = 16'h00FF; tgt[3] = 16'h0F0F;
        run(16'h0300, NW - 1);

        // R8: limit at index 5
        for (int i = 0; i < NW; i++) begin
            init_mem[i] = 16'hFFFF; tgt[i] = 16'h5A00 | 16'(i); need[i] = 1 + i % MAXP;
        end
        need[5] = MAXP + 1;
        run(16'h0410, NW - 1);

        // Constrained random runs
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < NW; i++) begin
                init_mem[i] = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
                tgt[i]      = init_mem[i] & 16'($urandom | $urandom);
                if ($urandom % 16 == 0) tgt[i] = tgt[i] | ~init_mem[i];
                need[i] = ($urandom % 16 == 0) ? MAXP + 1 : 1 + ($urandom % MAXP);
            end
            run(16'(((r + 1) * 40) & 16'hFFF8), int'($urandom % NW));
        end
        summary();
    end
endmodule